// File: doc/BRIEF.md
# Two-Level Coherence Message Predictor

This block sits next to a cache or directory controller and watches the coherence messages that arrive for each cache block. Every message is reduced to a tuple made of the sending node and the message kind. For each tracked block the predictor keeps the last few tuples. That recent history then selects, from a small table private to the block, the tuple that followed the same history last time. The result is a prediction of the next message the block will receive, which a protocol engine can use to act early.

The first level is a direct-mapped, tagged table indexed by the low bits of the block address. Each entry holds a shift register of the most recent `HIST_D` tuples. The second level is a set of `WAYS` fully associative pattern slots per entry. Each slot is tagged with a complete history value and holds a predicted tuple, guarded by a saturating confidence counter. Observations are applied on the clock edge. Queries are answered combinationally from the current state.

Top module: `coh_msg_predictor`

## Requirements
- R1: After reset, a query to any address returns `qryHit` = 0.
- R2: An observe whose address misses the first-level entry (entry empty, or upper address bits differ) reallocates that entry. The new history holds only the arriving tuple, all pattern slots of the entry are invalidated, and later queries find none of the old patterns.
- R3: No pattern is learned or returned until `HIST_D` tuples (default 2) have been observed since allocation. With history (X,Y) full, observing Z teaches "(X,Y) → Z".
- R4: A prediction returns the stored source (3 bits) and message kind (4 bits) exactly as observed. Any 4-bit kind code is accepted, including codes 10–15, which carry no named meaning.
- R5: A hitting pattern slot updates its 2-bit counter on each observe. The counter starts at 1 when the slot is created, increments on a correct prediction (saturating at 3), and decrements on a wrong one while non-zero. A wrong prediction with the counter at 0 replaces the stored tuple and sets the counter to 1.
- R6: When a full history matches no slot, the observe writes a new slot over the oldest-created slot of the entry (round-robin over `WAYS`, default 4), and the query for that history returns `qryHit` = 0.
- R7: A query and an observe to the same address in the same cycle return the prediction from before the update. The updated prediction appears on the next cycle.
- R8: A query whose upper address bits differ from the stored tag returns `qryHit` = 0, even if the index matches.
- R9: Entries at different indices learn and predict independently.
- R10: While `obsValid` is 0, the values on the observe inputs change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| obsValid | input | 1 | An observed message is present this cycle |
| obsAddr | input | 16 | Block address of the observed message |
| obsSrc | input | 3 | Sending node of the observed message |
| obsKind | input | 4 | Message kind code of the observed message |
| qryAddr | input | 16 | Block address being queried |
| qryHit | output | 1 | A prediction exists for `qryAddr` |
| qryPredSrc | output | 3 | Predicted sending node |
| qryPredKind | output | 4 | Predicted message kind |

## Verification
Query results depend combinationally on `qryAddr` and state, so they are due in the same cycle the address is driven. The effect of an observe is due on the first rising edge after it is presented. The bench drives every input at the falling edge and samples outputs one nanosecond later. A query therefore always reflects all observes applied at earlier rising edges. In the same-cycle test it shows the state before the observe, and again after the following edge. The expected tuples come from hand-tracing each history sequence against the requirements.

// File: rtl/coh_pred_pkg.sv
package coh_pred_pkg;
  localparam int SRC_W  = 3;
  localparam int KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    K_GET_RO_REQ = 4'd0,
    K_GET_RW_REQ = 4'd1,
    K_GET_RO_RSP = 4'd2,
    K_GET_RW_RSP = 4'd3,
    K_INV_RO_REQ = 4'd4,
    K_INV_RW_REQ = 4'd5,
    K_INV_RO_RSP = 4'd6,
    K_INV_RW_RSP = 4'd7,
    K_UPG_REQ    = 4'd8,
    K_UPG_RSP    = 4'd9
  } msgKind_e;

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [KIND_W-1:0] kind;
  } msgTuple_t;

  localparam int TUP_W = $bits(msgTuple_t);

  typedef struct packed {
    logic alloc;
    logic shift;
    logic wayNew;
    logic wayUpd;
    logic cntInc;
    logic cntDec;
    logic setPred;
  } ctrlStb_t;
endpackage

// File: rtl/coh_pred_ctrl.sv
module coh_pred_ctrl
  import coh_pred_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             obsValid,
  input  logic             entHit,
  input  logic             histFull,
  input  logic             wayHit,
  input  logic             predEq,
  input  logic [CNT_W-1:0] hitCnt,
  output ctrlStb_t         stb
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic learnable;

  always_comb begin
    learnable   = obsValid && entHit && histFull;
    stb         = '0;
    stb.alloc   = obsValid && !entHit;
    stb.shift   = obsValid;
    stb.wayNew  = learnable && !wayHit;
    stb.wayUpd  = learnable && wayHit;
    stb.cntInc  = stb.wayUpd && predEq && (hitCnt != CNT_MAX);
    stb.cntDec  = stb.wayUpd && !predEq && (hitCnt != '0);
    stb.setPred = stb.wayUpd && !predEq && (hitCnt == '0);
  end

  // R2 / R6: an observe either reallocates, creates a slot, or updates one
  a_r6_single_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.alloc, stb.wayNew, stb.wayUpd}));

endmodule

// File: rtl/coh_pred_datapath.sv
module coh_pred_datapath
  import coh_pred_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 16,
  parameter int HIST_D  = 2,
  parameter int WAYS    = 4,
  parameter int CNT_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] obsAddr,
  input  msgTuple_t         obsTuple,
  input  logic [ADDR_W-1:0] qryAddr,
  input  ctrlStb_t          stb,
  output logic              entHit,
  output logic              histFull,
  output logic              wayHit,
  output logic              predEq,
  output logic [CNT_W-1:0]  hitCnt,
  output logic              qryHit,
  output msgTuple_t         qryTuple
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int HIST_W = HIST_D * TUP_W;
  localparam int HC_W   = $clog2(HIST_D + 1);
  localparam int WAY_W  = $clog2(WAYS);
  localparam logic [HC_W-1:0]  HC_FULL  = HC_W'(HIST_D);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(1);

  logic              entV    [ENTRIES];
  logic [TAG_W-1:0]  tagMem  [ENTRIES];
  logic [HIST_W-1:0] hist    [ENTRIES];
  logic [HC_W-1:0]   histCnt [ENTRIES];
  logic [WAY_W-1:0]  rrPtr   [ENTRIES];
  logic              wayV    [ENTRIES][WAYS];
  logic [HIST_W-1:0] wayTag  [ENTRIES][WAYS];
  msgTuple_t         wayPred [ENTRIES][WAYS];
  logic [CNT_W-1:0]  wayCnt  [ENTRIES][WAYS];

  logic [IDX_W-1:0] oIdx, qIdx;
  logic [TAG_W-1:0] oTag, qTag;
  logic [WAY_W-1:0] hitWay, qWay;
  logic             qWayHit;
  logic [HIST_W+TUP_W-1:0] shifted;

  assign oIdx = obsAddr[IDX_W-1:0];
  assign oTag = obsAddr[ADDR_W-1:IDX_W];
  assign qIdx = qryAddr[IDX_W-1:0];
  assign qTag = qryAddr[ADDR_W-1:IDX_W];
  assign shifted = {hist[oIdx], obsTuple};

  // observe-side lookup
  always_comb begin
    entHit   = entV[oIdx] && (tagMem[oIdx] == oTag);
    histFull = (histCnt[oIdx] == HC_FULL);
    wayHit   = 1'b0;
    hitWay   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (wayV[oIdx][w] && (wayTag[oIdx][w] == hist[oIdx])) begin
        wayHit = 1'b1;
        hitWay = WAY_W'(w);
      end
    end
    predEq = (wayPred[oIdx][hitWay] == obsTuple);
    hitCnt = wayCnt[oIdx][hitWay];
  end

  // query-side lookup
  always_comb begin
    qWayHit = 1'b0;
    qWay    = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (wayV[qIdx][w] && (wayTag[qIdx][w] == hist[qIdx])) begin
        qWayHit = 1'b1;
        qWay    = WAY_W'(w);
      end
    end
    qryHit   = entV[qIdx] && (tagMem[qIdx] == qTag) &&
               (histCnt[qIdx] == HC_FULL) && qWayHit;
    qryTuple = wayPred[qIdx][qWay];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        entV[e]    <= 1'b0;
        tagMem[e]  <= '0;
        hist[e]    <= '0;
        histCnt[e] <= '0;
        rrPtr[e]   <= '0;
        for (int w = 0; w < WAYS; w++) begin
          wayV[e][w]    <= 1'b0;
          wayTag[e][w]  <= '0;
          wayPred[e][w] <= '0;
          wayCnt[e][w]  <= '0;
        end
      end
    end else begin
      if (stb.alloc) begin
        entV[oIdx]    <= 1'b1;
        tagMem[oIdx]  <= oTag;
        hist[oIdx]    <= HIST_W'(obsTuple);
        histCnt[oIdx] <= HC_W'(1);
        rrPtr[oIdx]   <= '0;
        for (int w = 0; w < WAYS; w++) wayV[oIdx][w] <= 1'b0;
      end else if (stb.shift) begin
        hist[oIdx] <= shifted[HIST_W-1:0];
        if (!histFull) histCnt[oIdx] <= histCnt[oIdx] + HC_W'(1);
      end
      if (stb.wayNew) begin
        wayV[oIdx][rrPtr[oIdx]]    <= 1'b1;
        wayTag[oIdx][rrPtr[oIdx]]  <= hist[oIdx];
        wayPred[oIdx][rrPtr[oIdx]] <= obsTuple;
        wayCnt[oIdx][rrPtr[oIdx]]  <= CNT_INIT;
        rrPtr[oIdx]                <= rrPtr[oIdx] + WAY_W'(1);
      end
      if (stb.wayUpd) begin
        if (stb.cntInc) wayCnt[oIdx][hitWay] <= hitCnt + CNT_W'(1);
        if (stb.cntDec) wayCnt[oIdx][hitWay] <= hitCnt - CNT_W'(1);
        if (stb.setPred) begin
          wayPred[oIdx][hitWay] <= obsTuple;
          wayCnt[oIdx][hitWay]  <= CNT_INIT;
        end
      end
    end
  end

  // R2: a reallocated entry restarts with exactly one tuple of history
  a_r2_alloc_restart: assert property (@(posedge clk) disable iff (!rst_n)
    stb.alloc |=> histCnt[$past(oIdx)] == HC_W'(1));

  // R6: creating a slot advances that entry's replacement pointer by one
  a_r6_rr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wayNew |=> rrPtr[$past(oIdx)] == $past(rrPtr[oIdx]) + WAY_W'(1));

  // R5: a stored prediction survives any update that is not a replacement
  a_r5_pred_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wayUpd && !stb.setPred) |=>
      wayPred[$past(oIdx)][$past(hitWay)] == $past(wayPred[oIdx][hitWay]));

  // R3: learning happens only with a full history
  a_r3_full_before_learn: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wayNew || stb.wayUpd) |-> histCnt[oIdx] == HC_FULL);

endmodule

// File: rtl/coh_msg_predictor.sv
module coh_msg_predictor
  import coh_pred_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 16,
  parameter int HIST_D  = 2,
  parameter int WAYS    = 4,
  parameter int CNT_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              obsValid,
  input  logic [ADDR_W-1:0] obsAddr,
  input  logic [SRC_W-1:0]  obsSrc,
  input  logic [KIND_W-1:0] obsKind,
  input  logic [ADDR_W-1:0] qryAddr,
  output logic              qryHit,
  output logic [SRC_W-1:0]  qryPredSrc,
  output logic [KIND_W-1:0] qryPredKind
);
  ctrlStb_t         stb;
  msgTuple_t        obsTuple, qryTuple;
  logic             entHit, histFull, wayHit, predEq;
  logic [CNT_W-1:0] hitCnt;

  assign obsTuple    = '{src: obsSrc, kind: obsKind};
  assign qryPredSrc  = qryTuple.src;
  assign qryPredKind = qryTuple.kind;

  coh_pred_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .obsValid(obsValid), .entHit(entHit),
    .histFull(histFull), .wayHit(wayHit), .predEq(predEq),
    .hitCnt(hitCnt), .stb(stb)
  );

  coh_pred_datapath #(
    .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .HIST_D(HIST_D),
    .WAYS(WAYS), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .obsAddr(obsAddr), .obsTuple(obsTuple),
    .qryAddr(qryAddr), .stb(stb), .entHit(entHit), .histFull(histFull),
    .wayHit(wayHit), .predEq(predEq), .hitCnt(hitCnt),
    .qryHit(qryHit), .qryTuple(qryTuple)
  );

  // R7 / R10: with no observe applied and a steady address, the answer holds
  a_r10_query_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(obsValid) && $stable(qryAddr)) |->
      ($stable(qryHit) && $stable(qryPredSrc) && $stable(qryPredKind)));

endmodule

// File: tb/coh_msg_predictor_test.sv
module coh_msg_predictor_test;
  import coh_pred_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        obsValid = 1'b0;
  logic [15:0] obsAddr = '0;
  logic [2:0]  obsSrc = '0;
  logic [3:0]  obsKind = '0;
  logic [15:0] qryAddr = '0;
  logic        qryHit;
  logic [2:0]  qryPredSrc;
  logic [3:0]  qryPredKind;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  coh_msg_predictor uut (
    .clk(clk), .rst_n(rst_n), .obsValid(obsValid), .obsAddr(obsAddr),
    .obsSrc(obsSrc), .obsKind(obsKind), .qryAddr(qryAddr),
    .qryHit(qryHit), .qryPredSrc(qryPredSrc), .qryPredKind(qryPredKind)
  );

  localparam logic [2:0] P = 3'd2, C = 3'd5;

  task automatic obs(input logic [15:0] a, input logic [2:0] s, input logic [3:0] k);
    @(negedge clk);
    obsValid = 1'b1; obsAddr = a; obsSrc = s; obsKind = k;
    @(negedge clk);
    obsValid = 1'b0;
  endtask

  task automatic chk(input string req, input logic [15:0] a, input bit expV,
                     input logic [2:0] s, input logic [3:0] k);
    qryAddr = a;
    #1;
    checks++;
    if (qryHit !== expV || (expV && (qryPredSrc !== s || qryPredKind !== k))) begin
      failures++;
      $display("FAIL %s addr=%h actual hit=%b src=%0d kind=%0d expected hit=%b src=%0d kind=%0d",
               req, a, qryHit, qryPredSrc, qryPredKind, expV, s, k);
    end
  endtask

  task automatic t_reset();
    chk("R1", 16'h0000, 0, 0, 0);
    chk("R1", 16'h0010, 0, 0, 0);
    chk("R1", 16'hFFFF, 0, 0, 0);
  endtask

  task automatic t_signature();
    obs(16'h0010, P, K_GET_RW_REQ);
    chk("R2", 16'h0010, 0, 0, 0);
    obs(16'h0010, C, K_INV_RO_RSP);
    chk("R3", 16'h0010, 0, 0, 0);
    obs(16'h0010, C, K_GET_RO_REQ);
    obs(16'h0010, P, K_INV_RW_RSP);
    obs(16'h0010, P, K_GET_RW_REQ);
    obs(16'h0010, C, K_INV_RO_RSP);
    chk("R3", 16'h0010, 1, C, K_GET_RO_REQ);
    obs(16'h0010, C, K_GET_RO_REQ);
    chk("R3", 16'h0010, 1, P, K_INV_RW_RSP);
  endtask

  // R4/R5: A uses src 7 kind 15, B uses src 0 kind 9
  task automatic t_filter();
    obs(16'h0021, 7, 15); obs(16'h0021, 7, 15);
    chk("R3", 16'h0021, 0, 0, 0);
    obs(16'h0021, 7, 15);
    chk("R4", 16'h0021, 1, 7, 15);
    obs(16'h0021, 0, 9);
    chk("R6", 16'h0021, 0, 0, 0);
    obs(16'h0021, 7, 15); obs(16'h0021, 7, 15);
    chk("R5", 16'h0021, 1, 7, 15);
    obs(16'h0021, 0, 9); obs(16'h0021, 7, 15); obs(16'h0021, 7, 15);
    chk("R5", 16'h0021, 1, 0, 9);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 6; i++) obs(16'h0032, 1, 3);
    chk("R5", 16'h0032, 1, 1, 3);
    for (int r = 0; r < 3; r++) begin
      obs(16'h0032, 4, 8); obs(16'h0032, 1, 3); obs(16'h0032, 1, 3);
      chk("R5", 16'h0032, 1, 1, 3);
    end
    obs(16'h0032, 4, 8); obs(16'h0032, 1, 3); obs(16'h0032, 1, 3);
    chk("R5", 16'h0032, 1, 4, 8);
  endtask

  task automatic t_replace();
    for (int i = 0; i < 7; i++) obs(16'h0043, 3'(i), 4'(i + 2));
    chk("R6", 16'h0043, 0, 0, 0);
    obs(16'h0043, 3'd0, 4'd2);
    obs(16'h0043, 3'd1, 4'd3);
    chk("R6", 16'h0043, 0, 0, 0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    obsValid = 1'b1; obsAddr = 16'h0010; obsSrc = P; obsKind = K_INV_RW_RSP;
    chk("R7", 16'h0010, 1, P, K_INV_RW_RSP);
    @(negedge clk);
    obsValid = 1'b0;
    chk("R7", 16'h0010, 1, P, K_GET_RW_REQ);
  endtask

  task automatic t_tag_miss();
    obs(16'h1010, C, K_UPG_REQ);
    chk("R8", 16'h0010, 0, 0, 0);
    chk("R3", 16'h1010, 0, 0, 0);
    obs(16'h0010, P, K_GET_RW_REQ);
    obs(16'h0010, C, K_INV_RO_RSP);
    chk("R2", 16'h0010, 0, 0, 0);
  endtask

  task automatic t_independent();
    chk("R9", 16'h0021, 1, 0, 9);
    chk("R8", 16'h1021, 0, 0, 0);
    @(negedge clk);
    obsValid = 1'b0; obsAddr = 16'h0021; obsSrc = 6; obsKind = 1;
    repeat (3) @(negedge clk);
    chk("R10", 16'h0021, 1, 0, 9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_signature();
    t_filter();
    t_saturate();
    t_replace();
    t_same_cycle();
    t_tag_miss();
    t_independent();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule